// File: doc/BRIEF.md
# Colour Lookup Palette Port

This block is the processor-facing side of a 256-entry colour lookup table. Each entry holds one colour triple made of red, green and blue components, each 6 bits wide. Software reaches the table through a small group of byte-wide registers: an address register for loading entries, an address register for fetching them, a single data port, a pixel mask and a read-only direction state. A hidden component counter walks red, green and blue on successive data-port accesses. After the third access it moves the active address on to the next entry. Writing address 0 and then streaming 768 bytes therefore fills the whole table.

On the display side, a pixel index arrives every cycle. The block ANDs it with the mask register, looks up the masked entry and presents the stored triple one clock later.

Register select codes on `cpu_sel` are: 0 = pixel mask (read and write), 1 = load fetch address on write / direction state on read, 2 = load address (read back returns its current value), 3 = data port.

Top module: `clut_port`

## Requirements
- R1: A write with select 2 loads the load address from `cpu_wdata` and returns the component counter to red. Afterwards a read with select 1 returns 0 in bits 1:0.
- R2: A write with select 1 loads the fetch address and returns the component counter to red. Afterwards a read with select 1 returns 3 in bits 1:0.
- R3: Successive data-port accesses step through red, then green, then blue. A data read returns the current component of the entry at the fetch address, in bits 5:0, with the upper bits zero.
- R4: The third data access (blue) increments the address in use: the load address for writes, the fetch address for reads. The increment wraps from 255 to 0. The red and green accesses leave both addresses unchanged.
- R5: A data write stores only bits 5:0. The red and green bytes are held until the blue byte arrives. The entry then changes as a whole, so a partly written entry still shows its old value at the pixel port.
- R6: Writing address 0 and then 768 data bytes loads every entry of the table, in order.
- R7: The pixel outputs show the entry at (`pix_idx` AND mask) one clock after `pix_idx` is applied.
- R8: The mask register resets to 0xFF, reads back at select 0, and changes only on a write with select 0.
- R9: A read with select 2 returns the load address, including the increments made by data writes.
- R10: When `cpu_wr` and `cpu_rd` are high together, the write is performed and the read is ignored: `cpu_rdata` and the component counter are not changed by the read.
- R11: Reset leaves the direction state at 0, the load address at 0, the component counter at red, and the pixel outputs and `cpu_rdata` at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_wr | input | 1 | Register write strobe, one access per cycle |
| cpu_rd | input | 1 | Register read strobe, one access per cycle |
| cpu_sel | input | 2 | Register select |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data, registered, valid the cycle after the read |
| pix_idx | input | 8 | Pixel colour index |
| pix_red | output | 6 | Red component of the looked-up entry |
| pix_green | output | 6 | Green component of the looked-up entry |
| pix_blue | output | 6 | Blue component of the looked-up entry |

## Verification
On every cycle, the assertions check the following:
- address loads clear the counter and set the direction;
- the counter never takes its unused code and only moves on an access;
- only the blue access increments an address, with wrap;
- the mask changes only when written;
- data reads return clean upper bits;
- a collided read leaves `cpu_rdata` alone.

Only the bench's scenarios can show what the table itself holds. That covers the ordering of a full 768-byte load, the atomic commit of a triple at the pixel port, the masking of pixel indices, and the read-back order across the 255-to-0 wrap. A restarted partial entry must also leave its first target untouched.

// File: rtl/clut_pkg.sv
package clut_pkg;

    localparam int DEF_IDX_W  = 8;
    localparam int DEF_COMP_W = 6;
    localparam int NUM_COMP   = 3;

    typedef enum logic [1:0] {
        SEL_MASK = 2'd0,
        SEL_RADR = 2'd1,
        SEL_WADR = 2'd2,
        SEL_DATA = 2'd3
    } sel_e;

    typedef enum logic [1:0] {
        C_RED = 2'd0,
        C_GRN = 2'd1,
        C_BLU = 2'd2
    } comp_e;

    typedef enum logic {
        DIR_LOAD  = 1'b0,
        DIR_FETCH = 1'b1
    } dir_e;

    function automatic comp_e comp_next(input comp_e c);
        case (c)
            C_RED:   return C_GRN;
            C_GRN:   return C_BLU;
            default: return C_RED;
        endcase
    endfunction

    function automatic logic [1:0] state_code(input dir_e d);
        return (d == DIR_FETCH) ? 2'b11 : 2'b00;
    endfunction

endpackage

// File: rtl/clut_seq.sv
module clut_seq
    import clut_pkg::*;
#(
    parameter int IDX_W  = DEF_IDX_W,
    parameter int COMP_W = DEF_COMP_W
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       cpu_wr,
    input  logic                       cpu_rd,
    input  sel_e                       cpu_sel,
    input  logic [IDX_W-1:0]           cpu_wdata,
    output logic [IDX_W-1:0]           wr_addr,
    output logic [IDX_W-1:0]           rd_addr,
    output comp_e                      comp,
    output dir_e                       dir,
    output logic [IDX_W-1:0]           mask,
    output logic                       ram_we,
    output logic [IDX_W-1:0]           ram_waddr,
    output logic [NUM_COMP*COMP_W-1:0] ram_wdata
);

    logic              wr_acc, rd_acc, data_wr, data_rd;
    logic [COMP_W-1:0] stg_red, stg_grn;

    // a write wins over a read presented in the same cycle
    assign wr_acc  = cpu_wr;
    assign rd_acc  = cpu_rd && !cpu_wr;
    assign data_wr = wr_acc && (cpu_sel == SEL_DATA);
    assign data_rd = rd_acc && (cpu_sel == SEL_DATA);

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_addr <= '0;
            rd_addr <= '0;
            comp    <= C_RED;
            dir     <= DIR_LOAD;
            mask    <= '1;
            stg_red <= '0;
            stg_grn <= '0;
        end else if (wr_acc) begin
            case (cpu_sel)
                SEL_MASK: mask <= cpu_wdata;
                SEL_RADR: begin
                    rd_addr <= cpu_wdata;
                    comp    <= C_RED;
                    dir     <= DIR_FETCH;
                end
                SEL_WADR: begin
                    wr_addr <= cpu_wdata;
                    comp    <= C_RED;
                    dir     <= DIR_LOAD;
                end
                default: begin
                    comp <= comp_next(comp);
                    case (comp)
                        C_RED:   stg_red <= cpu_wdata[COMP_W-1:0];
                        C_GRN:   stg_grn <= cpu_wdata[COMP_W-1:0];
                        default: wr_addr <= wr_addr + 1'b1;
                    endcase
                end
            endcase
        end else if (data_rd) begin
            comp <= comp_next(comp);
            if (comp == C_BLU) begin
                rd_addr <= rd_addr + 1'b1;
            end
        end
    end

    // the whole triple lands in the table together with the blue byte
    assign ram_we    = data_wr && (comp == C_BLU);
    assign ram_waddr = wr_addr;
    assign ram_wdata = {stg_red, stg_grn, cpu_wdata[COMP_W-1:0]};

endmodule

// File: rtl/clut_ram.sv
module clut_ram #(
    parameter int IDX_W = 8,
    parameter int ENT_W = 18
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  logic [ENT_W-1:0] wdata,
    input  logic [IDX_W-1:0] a_addr,
    output logic [ENT_W-1:0] a_data,
    input  logic [IDX_W-1:0] b_addr,
    output logic [ENT_W-1:0] b_data
);

    localparam int DEPTH = 1 << IDX_W;

    logic [ENT_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign a_data = mem[a_addr];
    assign b_data = mem[b_addr];

endmodule

// File: rtl/clut_pix.sv
module clut_pix
    import clut_pkg::*;
#(
    parameter int IDX_W  = DEF_IDX_W,
    parameter int COMP_W = DEF_COMP_W
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [IDX_W-1:0]           pix_idx,
    input  logic [IDX_W-1:0]           mask,
    output logic [IDX_W-1:0]           lk_addr,
    input  logic [NUM_COMP*COMP_W-1:0] lk_data,
    output logic [COMP_W-1:0]          out_red,
    output logic [COMP_W-1:0]          out_grn,
    output logic [COMP_W-1:0]          out_blu
);

    logic [COMP_W-1:0] comp_q [NUM_COMP];

    assign lk_addr = pix_idx & mask;

    // component 0 (red) sits in the most significant slice of an entry
    for (genvar c = 0; c < NUM_COMP; c++) begin : g_comp
        always_ff @(posedge clk) begin
            if (rst) begin
                comp_q[c] <= '0;
            end else begin
                comp_q[c] <= lk_data[(NUM_COMP-c)*COMP_W-1 -: COMP_W];
            end
        end
    end

    assign out_red = comp_q[0];
    assign out_grn = comp_q[1];
    assign out_blu = comp_q[2];

endmodule

// File: rtl/clut_port.sv
module clut_port
    import clut_pkg::*;
#(
    parameter int IDX_W  = DEF_IDX_W,
    parameter int COMP_W = DEF_COMP_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_wr,
    input  logic              cpu_rd,
    input  logic [1:0]        cpu_sel,
    input  logic [IDX_W-1:0]  cpu_wdata,
    output logic [IDX_W-1:0]  cpu_rdata,
    input  logic [IDX_W-1:0]  pix_idx,
    output logic [COMP_W-1:0] pix_red,
    output logic [COMP_W-1:0] pix_green,
    output logic [COMP_W-1:0] pix_blue
);

    localparam int ENT_W = NUM_COMP * COMP_W;

    sel_e              sel;
    logic [IDX_W-1:0]  wr_addr_q, rd_addr_q, mask_q, lk_addr;
    comp_e             comp_q;
    dir_e              dir_q;
    logic              ram_we;
    logic [IDX_W-1:0]  ram_waddr;
    logic [ENT_W-1:0]  ram_wdata, rd_ent, lk_ent;
    logic [COMP_W-1:0] rd_comp;

    assign sel = sel_e'(cpu_sel);

    clut_seq #(.IDX_W(IDX_W), .COMP_W(COMP_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .cpu_wr    (cpu_wr),
        .cpu_rd    (cpu_rd),
        .cpu_sel   (sel),
        .cpu_wdata (cpu_wdata),
        .wr_addr   (wr_addr_q),
        .rd_addr   (rd_addr_q),
        .comp      (comp_q),
        .dir       (dir_q),
        .mask      (mask_q),
        .ram_we    (ram_we),
        .ram_waddr (ram_waddr),
        .ram_wdata (ram_wdata)
    );

    clut_ram #(.IDX_W(IDX_W), .ENT_W(ENT_W)) u_ram (
        .clk    (clk),
        .we     (ram_we),
        .waddr  (ram_waddr),
        .wdata  (ram_wdata),
        .a_addr (rd_addr_q),
        .a_data (rd_ent),
        .b_addr (lk_addr),
        .b_data (lk_ent)
    );

    clut_pix #(.IDX_W(IDX_W), .COMP_W(COMP_W)) u_pix (
        .clk     (clk),
        .rst     (rst),
        .pix_idx (pix_idx),
        .mask    (mask_q),
        .lk_addr (lk_addr),
        .lk_data (lk_ent),
        .out_red (pix_red),
        .out_grn (pix_green),
        .out_blu (pix_blue)
    );

    always_comb begin
        case (comp_q)
            C_RED:   rd_comp = rd_ent[ENT_W-1 -: COMP_W];
            C_GRN:   rd_comp = rd_ent[2*COMP_W-1 -: COMP_W];
            default: rd_comp = rd_ent[COMP_W-1:0];
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cpu_rdata <= '0;
        end else if (cpu_rd && !cpu_wr) begin
            case (sel)
                SEL_MASK: cpu_rdata <= mask_q;
                SEL_RADR: cpu_rdata <= IDX_W'(state_code(dir_q));
                SEL_WADR: cpu_rdata <= wr_addr_q;
                default:  cpu_rdata <= IDX_W'(rd_comp);
            endcase
        end
    end

endmodule

// File: rtl/clut_port_chk.sv
module clut_port_chk #(
    parameter int IDX_W  = 8,
    parameter int COMP_W = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             cpu_wr,
    input logic             cpu_rd,
    input logic [1:0]       cpu_sel,
    input logic [IDX_W-1:0] cpu_wdata,
    input logic [IDX_W-1:0] cpu_rdata,
    input logic [IDX_W-1:0] wr_addr,
    input logic [IDX_W-1:0] rd_addr,
    input logic [1:0]       comp,
    input logic             dir,
    input logic [IDX_W-1:0] mask
);

    assert_waddr_load_R1: assert property (@(posedge clk) disable iff (rst)
        cpu_wr && cpu_sel == 2'd2 |=> wr_addr == $past(cpu_wdata) && comp == 2'd0 && !dir);

    assert_raddr_load_R2: assert property (@(posedge clk) disable iff (rst)
        cpu_wr && cpu_sel == 2'd1 |=> rd_addr == $past(cpu_wdata) && comp == 2'd0 && dir);

    assert_comp_legal_R3: assert property (@(posedge clk) disable iff (rst)
        comp != 2'd3);

    assert_comp_idle_R3: assert property (@(posedge clk) disable iff (rst)
        !cpu_wr && !cpu_rd |=> $stable(comp));

    assert_rdata_upper_R3: assert property (@(posedge clk) disable iff (rst)
        cpu_rd && !cpu_wr && cpu_sel == 2'd3 |=> (cpu_rdata >> COMP_W) == '0);

    assert_wr_bump_R4: assert property (@(posedge clk) disable iff (rst)
        cpu_wr && cpu_sel == 2'd3 && comp == 2'd2 |=> wr_addr == IDX_W'($past(wr_addr) + 1'b1));

    assert_rd_bump_R4: assert property (@(posedge clk) disable iff (rst)
        cpu_rd && !cpu_wr && cpu_sel == 2'd3 && comp == 2'd2
        |=> rd_addr == IDX_W'($past(rd_addr) + 1'b1));

    assert_addr_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr || cpu_rd) && cpu_sel == 2'd3 && comp != 2'd2
        |=> $stable(wr_addr) && $stable(rd_addr));

    assert_mask_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !(cpu_wr && cpu_sel == 2'd0) |=> $stable(mask));

    assert_collide_R10: assert property (@(posedge clk) disable iff (rst)
        cpu_wr && cpu_rd |=> $stable(cpu_rdata));

endmodule

bind clut_port clut_port_chk #(.IDX_W(IDX_W), .COMP_W(COMP_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cpu_wr    (cpu_wr),
    .cpu_rd    (cpu_rd),
    .cpu_sel   (cpu_sel),
    .cpu_wdata (cpu_wdata),
    .cpu_rdata (cpu_rdata),
    .wr_addr   (wr_addr_q),
    .rd_addr   (rd_addr_q),
    .comp      (comp_q),
    .dir       (dir_q),
    .mask      (mask_q)
);

// File: tb/tb_clut_port.sv
module tb_clut_port;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cpu_wr = 1'b0;
    logic       cpu_rd = 1'b0;
    logic [1:0] cpu_sel = 2'd0;
    logic [7:0] cpu_wdata = 8'd0;
    logic [7:0] cpu_rdata;
    logic [7:0] pix_idx = 8'd0;
    logic [5:0] pix_red, pix_green, pix_blue;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    logic [17:0] model [256];

    always #2 clk = ~clk;

    clut_port dut (
        .clk       (clk),
        .rst       (rst),
        .cpu_wr    (cpu_wr),
        .cpu_rd    (cpu_rd),
        .cpu_sel   (cpu_sel),
        .cpu_wdata (cpu_wdata),
        .cpu_rdata (cpu_rdata),
        .pix_idx   (pix_idx),
        .pix_red   (pix_red),
        .pix_green (pix_green),
        .pix_blue  (pix_blue)
    );

    function automatic logic [5:0] pat(input int i, input int c);
        return 6'((i * 5 + c * 23 + 7) & 63);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // one register access; rdata sampled at the negedge after the capturing edge
    task automatic acc(input logic w, input logic r, input logic [1:0] sel,
                       input logic [7:0] d, output logic [7:0] q);
        @(negedge clk);
        cpu_wr = w; cpu_rd = r; cpu_sel = sel; cpu_wdata = d;
        @(negedge clk);
        cpu_wr = 1'b0; cpu_rd = 1'b0;
        q = cpu_rdata;
    endtask

    task automatic wr(input logic [1:0] sel, input logic [7:0] d);
        logic [7:0] q;
        acc(1'b1, 1'b0, sel, d, q);
    endtask

    task automatic rd(input logic [1:0] sel, output logic [7:0] q);
        acc(1'b0, 1'b1, sel, 8'd0, q);
    endtask

    task automatic look(input logic [7:0] idx, output logic [17:0] ent);
        @(negedge clk);
        pix_idx = idx;
        @(negedge clk);
        ent = {pix_red, pix_green, pix_blue};
    endtask

    task automatic t_reset();
        logic [7:0] q;
        repeat (3) @(negedge clk);
        check("R11 pixel outputs in reset", {pix_red, pix_green, pix_blue}, 18'd0);
        check("R11 rdata in reset", cpu_rdata, 8'd0);
        rst = 1'b0;
        rd(2'd1, q); check("R11 state after reset", q[1:0], 2'b00);
        rd(2'd0, q); check("R8 mask reset value", q, 8'hFF);
        rd(2'd2, q); check("R11 load address after reset", q, 8'd0);
    endtask

    task automatic t_full_load();
        logic [7:0] q;
        wr(2'd2, 8'd0);
        for (int i = 0; i < 256; i++) begin
            for (int c = 0; c < 3; c++) begin
                wr(2'd3, {2'b11, pat(i, c)});
            end
            model[i] = {pat(i, 0), pat(i, 1), pat(i, 2)};
        end
        rd(2'd2, q); check("R4 load address wrapped after 768 writes", q, 8'd0);
        rd(2'd1, q); check("R1 state after data writes", q[1:0], 2'b00);
        wr(2'd1, 8'd0);
        rd(2'd1, q); check("R2 state after fetch address load", q[1:0], 2'b11);
        for (int i = 0; i < 256; i++) begin
            for (int c = 0; c < 3; c++) begin
                rd(2'd3, q);
                check("R6 R3 full table readback", q, {2'b00, pat(i, c)});
            end
        end
    endtask

    task automatic t_pixel();
        logic [17:0] e;
        logic [7:0]  q;
        look(8'd0,   e); check("R7 pixel idx 0",   e, model[0]);
        look(8'd1,   e); check("R7 pixel idx 1",   e, model[1]);
        look(8'd77,  e); check("R7 pixel idx 77",  e, model[77]);
        look(8'd128, e); check("R7 pixel idx 128", e, model[128]);
        look(8'd255, e); check("R7 pixel idx 255", e, model[255]);
        wr(2'd0, 8'h0F);
        rd(2'd0, q); check("R8 mask readback", q, 8'h0F);
        look(8'hF3, e); check("R7 masked idx F3 & 0F", e, model[8'h03]);
        wr(2'd0, 8'h00);
        look(8'hA5, e); check("R7 mask zero gives entry 0", e, model[0]);
        wr(2'd0, 8'hFF);
        look(8'hA5, e); check("R7 full mask idx A5", e, model[8'hA5]);
    endtask

    task automatic t_commit();
        logic [17:0] e;
        logic [7:0]  q;
        wr(2'd2, 8'd40);
        wr(2'd3, 8'h3A);
        wr(2'd3, 8'h15);
        look(8'd40, e); check("R5 partial entry keeps old value", e, model[40]);
        rd(2'd2, q); check("R4 address held before blue", q, 8'd40);
        wr(2'd3, 8'hE7);
        model[40] = {6'h3A, 6'h15, 6'h27};
        look(8'd40, e); check("R5 entry committed on blue, bits 5:0 only", e, model[40]);
        rd(2'd2, q); check("R9 load address after increment", q, 8'd41);
    endtask

    task automatic t_wrap();
        logic [7:0]  q;
        logic [17:0] e;
        wr(2'd2, 8'd255);
        wr(2'd3, 8'h01); wr(2'd3, 8'h02); wr(2'd3, 8'h03);
        model[255] = {6'h01, 6'h02, 6'h03};
        rd(2'd2, q); check("R4 load address wraps 255 to 0", q, 8'd0);
        look(8'd255, e); check("R4 entry 255 written before wrap", e, model[255]);
        wr(2'd1, 8'd255);
        rd(2'd3, q); check("R3 red first", q, 8'h01);
        rd(2'd3, q); check("R3 green second", q, 8'h02);
        rd(2'd3, q); check("R3 blue third", q, 8'h03);
        rd(2'd3, q); check("R4 fetch address wraps to entry 0", q, {2'b00, model[0][17:12]});
    endtask

    task automatic t_restart();
        logic [17:0] e;
        logic [7:0]  q;
        wr(2'd2, 8'd10);
        wr(2'd3, 8'h11);
        wr(2'd2, 8'd20);
        wr(2'd3, 8'h21); wr(2'd3, 8'h22); wr(2'd3, 8'h23);
        model[20] = {6'h21, 6'h22, 6'h23};
        look(8'd20, e); check("R1 reload restarts counter at red", e, model[20]);
        look(8'd10, e); check("R1 abandoned entry unchanged", e, model[10]);
        rd(2'd1, q); check("R1 state after load address write", q[1:0], 2'b00);
    endtask

    task automatic t_collide();
        logic [7:0] q;
        wr(2'd1, 8'd0);
        rd(2'd3, q); check("R3 collision setup red of entry 0", q, {2'b00, model[0][17:12]});
        acc(1'b1, 1'b1, 2'd0, 8'hAA, q);
        check("R10 read ignored, rdata held", q, {2'b00, model[0][17:12]});
        rd(2'd0, q); check("R10 write performed on collision", q, 8'hAA);
        wr(2'd0, 8'hFF);
        rd(2'd3, q); check("R10 counter not moved by ignored read", q, {2'b00, model[0][11:6]});
    endtask

    initial begin
        t_reset();
        t_full_load();
        t_pixel();
        t_commit();
        t_wrap();
        t_restart();
        t_collide();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule